// File: doc/BRIEF.md
# Commit-Stage Exception and Interrupt Sequencer

This block sits where instructions retire in an in-order pipeline. Every cycle it looks at all pending candidates: two abort sources (hardware reset request and machine check), an initialisation request, a system-management request, trap and software-interrupt conditions raised by the retiring instruction, non-maskable and maskable external interrupts, execute-stage faults and fetch/decode faults. It grants exactly one of them by a fixed class order. The grant flushes every younger instruction and records a cause vector, a return PC and a resumable flag. It then steers fetch to the handler at `handlerBase + vector*16`.

The return PC depends on the class of the winner. A fault restarts the offending instruction. A trap or software interrupt resumes after the instruction, or at its jump target when the jump was taken. An external interrupt, init or system-management request resumes at the retiring instruction, which was nullified. An abort leaves the saved PC alone and marks the state as not resumable. A return strobe sends fetch back to the saved PC and restores the interrupt enable that was in force before the grant. Candidates that lose arbitration are dropped and must be raised again by their source.

Top module: `commit_event_unit`

## Requirements
- R1: While `rst` is high at a clock edge (synchronous, active high), the next cycle shows `flush`, `redirect`, `irqEnable` and `resumable` at 0, and `causeVector`, `savedPc` and `redirectPc` at zero.
- R2: Among the requests present in a cycle, only one is granted, in this order from highest to lowest: hwResetReq (vector 0x01), machineCheck (0x02), initReq (0x03), smiReq (0x04), softIntValid (vector = softIntVector), trapReq (0x05), nmiReq (0x06), irqReq (0x20), execFault bit 0 / data-TLB (0x08), execFault bit 1 / floating point (0x09), execFault bit 2 / alignment (0x0A), fetchFault bit 0 / instruction-TLB (0x0B), fetchFault bit 1 / illegal opcode (0x0C).
- R3: A grant in cycle t makes `flush` and `redirect` high for exactly cycle t+1, with `causeVector` equal to the granted vector and `redirectPc` equal to `handlerBase + vector*16`.
- R4: For an execute or fetch fault grant, `savedPc` becomes the `commitPc` of the grant cycle and `resumable` becomes 1.
- R5: For a trap or software-interrupt grant, `savedPc` becomes `commitTarget` when `commitTaken` is 1, and `commitPc + 4` otherwise. `resumable` becomes 1.
- R6: For an init, system-management, non-maskable or maskable interrupt grant, `savedPc` becomes the `commitPc` of the grant cycle and `resumable` becomes 1.
- R7: hwResetReq and machineCheck are granted whether or not `commitValid` is high. Their grant sets `resumable` to 0 and leaves `savedPc` unchanged.
- R8: `irqReq` is granted only while `irqEnable` is 1. `nmiReq` and `softIntValid` ignore `irqEnable`. When neither a grant nor a return occurs, `irqEnWe` loads `irqEnVal` into `irqEnable`.
- R9: All requests other than the two aborts are ignored in a cycle where `commitValid` is 0.
- R10: A request that loses arbitration is not remembered. If it is absent in later cycles, no grant follows for it.
- R11: A grant clears `irqEnable` and keeps its prior value. A return (`eret`) taken in cycle t restores that value and pulses `flush` and `redirect` in cycle t+1 with `redirectPc = savedPc`, leaving `causeVector` unchanged.
- R12: In a cycle where `redirect` is high, no grant or return is taken. A request grant has precedence over `eret` in the same cycle. `eret` is ignored while `resumable` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| commitValid | input | 1 | An instruction is at the retire boundary this cycle |
| commitPc | input | 32 | PC of the retiring instruction |
| commitTaken | input | 1 | Retiring instruction is a taken jump |
| commitTarget | input | 32 | Jump target of the retiring instruction |
| handlerBase | input | 32 | Base address of the handler table |
| hwResetReq | input | 1 | Hardware reset abort request |
| machineCheck | input | 1 | Machine-check abort request |
| initReq | input | 1 | Initialisation request |
| smiReq | input | 1 | System-management request |
| softIntValid | input | 1 | Retiring instruction is a software interrupt |
| softIntVector | input | 8 | Vector operand of the software interrupt |
| trapReq | input | 1 | Retiring instruction traps |
| nmiReq | input | 1 | Non-maskable interrupt |
| irqReq | input | 1 | Maskable interrupt |
| execFault | input | 3 | Execute faults: bit0 data-TLB, bit1 FP, bit2 alignment |
| fetchFault | input | 2 | Fetch faults: bit0 instruction-TLB, bit1 illegal opcode |
| eret | input | 1 | Return-from-handler strobe |
| irqEnWe | input | 1 | Write strobe for the interrupt enable |
| irqEnVal | input | 1 | Value written to the interrupt enable |
| flush | output | 1 | One-cycle pipeline flush |
| redirect | output | 1 | One-cycle fetch redirect strobe |
| redirectPc | output | 32 | Fetch target accompanying `redirect` |
| causeVector | output | 8 | Vector of the last grant |
| savedPc | output | 32 | Recorded return PC |
| resumable | output | 1 | Saved state may be returned to |
| irqEnable | output | 1 | Current maskable-interrupt enable |

## Verification
Arbitration is combinational and every result is registered once, so a grant or return made at clock edge t shows up on all outputs in the cycle right after that edge. This includes the flush/redirect pulse, the new cause, the saved PC, the resumable flag and the enable change. The cycle after that shows the pulse deasserted. The bench changes inputs shortly after the falling edge. Its reference model advances at each rising edge from those inputs, and every output is compared with the model at the next falling edge. A request held through the pulse cycle therefore shows the one-cycle blocking window directly. Sweeps raise every class at or below a given level at once, and a mixed random phase follows.

// File: rtl/cev_pkg.sv
package cev_pkg;
  localparam int VEC_W  = 8;
  localparam int NUM_EV = 13;
  localparam int EV_IDX_W = $clog2(NUM_EV);

  // Priority index of each candidate: lower index wins.
  localparam int EV_HWRST = 0;
  localparam int EV_MCHK  = 1;
  localparam int EV_INIT  = 2;
  localparam int EV_SMI   = 3;
  localparam int EV_SWINT = 4;
  localparam int EV_TRAP  = 5;
  localparam int EV_NMI   = 6;
  localparam int EV_IRQ   = 7;
  localparam int EV_DTLB  = 8;
  localparam int EV_FPE   = 9;
  localparam int EV_ALIGN = 10;
  localparam int EV_ITLB  = 11;
  localparam int EV_ILLOP = 12;

  typedef enum logic [1:0] {PC_CUR, PC_SEQ, PC_NONE} pcSel_e;

  typedef struct packed {
    logic             take;
    logic             ret;
    logic             enWrite;
    logic             enVal;
    pcSel_e           pcSel;
    logic [VEC_W-1:0] vec;
  } strobe_t;

  function automatic logic [VEC_W-1:0] evVector(input int idx, input logic [VEC_W-1:0] swVec);
    case (idx)
      EV_HWRST: return 8'h01;
      EV_MCHK:  return 8'h02;
      EV_INIT:  return 8'h03;
      EV_SMI:   return 8'h04;
      EV_SWINT: return swVec;
      EV_TRAP:  return 8'h05;
      EV_NMI:   return 8'h06;
      EV_IRQ:   return 8'h20;
      EV_DTLB:  return 8'h08;
      EV_FPE:   return 8'h09;
      EV_ALIGN: return 8'h0A;
      EV_ITLB:  return 8'h0B;
      default:  return 8'h0C;
    endcase
  endfunction

  function automatic pcSel_e evPcSel(input int idx);
    if (idx == EV_HWRST || idx == EV_MCHK) return PC_NONE;
    if (idx == EV_SWINT || idx == EV_TRAP) return PC_SEQ;
    return PC_CUR;
  endfunction
endpackage

// File: rtl/cev_ctrl.sv
module cev_ctrl
  import cev_pkg::*;
#(
  parameter int NUM = NUM_EV
) (
  input  logic             commitValid,
  input  logic [NUM-1:0]   rawReq,
  input  logic [VEC_W-1:0] softVector,
  input  logic             irqEnable,
  input  logic             pending,
  input  logic             eret,
  input  logic             resumable,
  input  logic             irqEnWe,
  input  logic             irqEnVal,
  output strobe_t          strb
);
  logic [NUM-1:0] gatedReq;

  for (genvar i = 0; i < NUM; i++) begin : gGate
    if (i <= EV_MCHK) begin : gAbort
      assign gatedReq[i] = rawReq[i];
    end else if (i == EV_IRQ) begin : gMask
      assign gatedReq[i] = rawReq[i] & commitValid & irqEnable;
    end else begin : gBoundary
      assign gatedReq[i] = rawReq[i] & commitValid;
    end
  end

  always_comb begin
    int winIdx;
    winIdx = NUM - 1;
    for (int i = NUM - 1; i >= 0; i--) begin
      if (gatedReq[i]) winIdx = i;
    end
    strb.take    = (|gatedReq) & ~pending;
    strb.ret     = ~(|gatedReq) & ~pending & eret & resumable;
    strb.enWrite = irqEnWe & ~strb.take & ~strb.ret;
    strb.enVal   = irqEnVal;
    strb.pcSel   = evPcSel(winIdx);
    strb.vec     = evVector(winIdx, softVector);
  end
endmodule

// File: rtl/cev_dp.sv
module cev_dp
  import cev_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int VEC_SHIFT  = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  strobe_t          strb,
  input  logic [PC_W-1:0]  commitPc,
  input  logic             commitTaken,
  input  logic [PC_W-1:0]  commitTarget,
  input  logic [PC_W-1:0]  handlerBase,
  output logic             flushQ,
  output logic             redirQ,
  output logic [PC_W-1:0]  redirPcQ,
  output logic [VEC_W-1:0] causeQ,
  output logic [PC_W-1:0]  savedPcQ,
  output logic             resumableQ,
  output logic             irqEnQ
);
  logic            savedEnQ;
  logic [PC_W-1:0] seqPc;
  logic [PC_W-1:0] handlerPc;

  assign seqPc     = commitTaken ? commitTarget : commitPc + PC_W'(INSN_BYTES);
  assign handlerPc = handlerBase + (PC_W'(strb.vec) << VEC_SHIFT);

  always_ff @(posedge clk) begin
    if (rst) begin
      flushQ     <= 1'b0;
      redirQ     <= 1'b0;
      redirPcQ   <= '0;
      causeQ     <= '0;
      savedPcQ   <= '0;
      resumableQ <= 1'b0;
      irqEnQ     <= 1'b0;
      savedEnQ   <= 1'b0;
    end else begin
      flushQ <= strb.take | strb.ret;
      redirQ <= strb.take | strb.ret;
      if (strb.take) begin
        causeQ   <= strb.vec;
        redirPcQ <= handlerPc;
        savedEnQ <= irqEnQ;
        irqEnQ   <= 1'b0;
        case (strb.pcSel)
          PC_CUR: begin
            savedPcQ   <= commitPc;
            resumableQ <= 1'b1;
          end
          PC_SEQ: begin
            savedPcQ   <= seqPc;
            resumableQ <= 1'b1;
          end
          default: resumableQ <= 1'b0;
        endcase
      end else if (strb.ret) begin
        redirPcQ <= savedPcQ;
        irqEnQ   <= savedEnQ;
      end else if (strb.enWrite) begin
        irqEnQ <= strb.enVal;
      end
    end
  end
endmodule

// File: rtl/commit_event_unit.sv
module commit_event_unit
  import cev_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int VEC_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commitValid,
  input  logic [PC_W-1:0]  commitPc,
  input  logic             commitTaken,
  input  logic [PC_W-1:0]  commitTarget,
  input  logic [PC_W-1:0]  handlerBase,
  input  logic             hwResetReq,
  input  logic             machineCheck,
  input  logic             initReq,
  input  logic             smiReq,
  input  logic             softIntValid,
  input  logic [VEC_W-1:0] softIntVector,
  input  logic             trapReq,
  input  logic             nmiReq,
  input  logic             irqReq,
  input  logic [2:0]       execFault,
  input  logic [1:0]       fetchFault,
  input  logic             eret,
  input  logic             irqEnWe,
  input  logic             irqEnVal,
  output logic             flush,
  output logic             redirect,
  output logic [PC_W-1:0]  redirectPc,
  output logic [VEC_W-1:0] causeVector,
  output logic [PC_W-1:0]  savedPc,
  output logic             resumable,
  output logic             irqEnable
);
  logic [NUM_EV-1:0] rawReq;
  strobe_t           strb;

  assign rawReq = {fetchFault[1], fetchFault[0], execFault[2], execFault[1], execFault[0],
                   irqReq, nmiReq, trapReq, softIntValid, smiReq, initReq,
                   machineCheck, hwResetReq};

  cev_ctrl #(.NUM(NUM_EV)) uCtrl (
    .commitValid (commitValid),
    .rawReq      (rawReq),
    .softVector  (softIntVector),
    .irqEnable   (irqEnable),
    .pending     (redirect),
    .eret        (eret),
    .resumable   (resumable),
    .irqEnWe     (irqEnWe),
    .irqEnVal    (irqEnVal),
    .strb        (strb)
  );

  cev_dp #(.PC_W(PC_W), .VEC_SHIFT(VEC_SHIFT), .INSN_BYTES(4)) uDp (
    .clk          (clk),
    .rst          (rst),
    .strb         (strb),
    .commitPc     (commitPc),
    .commitTaken  (commitTaken),
    .commitTarget (commitTarget),
    .handlerBase  (handlerBase),
    .flushQ       (flush),
    .redirQ       (redirect),
    .redirPcQ     (redirectPc),
    .causeQ       (causeVector),
    .savedPcQ     (savedPc),
    .resumableQ   (resumable),
    .irqEnQ       (irqEnable)
  );
endmodule

// File: rtl/cev_checker.sv
module cev_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            commitValid,
  input logic [PC_W-1:0] commitPc,
  input logic            hwResetReq,
  input logic            machineCheck,
  input logic            initReq,
  input logic            smiReq,
  input logic            softIntValid,
  input logic            trapReq,
  input logic            nmiReq,
  input logic            irqReq,
  input logic [2:0]      execFault,
  input logic [1:0]      fetchFault,
  input logic            eret,
  input logic            flush,
  input logic            redirect,
  input logic [7:0]      causeVector,
  input logic [PC_W-1:0] savedPc,
  input logic            resumable,
  input logic            irqEnable
);
  logic aboveNmi;
  logic othersIdle;
  assign aboveNmi   = hwResetReq | machineCheck | initReq | smiReq | softIntValid | trapReq;
  assign othersIdle = ~aboveNmi & ~nmiReq & ~(|execFault) & ~(|fetchFault) & ~eret;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!redirect && !flush && !irqEnable && !resumable && causeVector == 8'h00));

  assert_pulse_pair_R3: assert property (@(posedge clk) disable iff (rst)
    flush == redirect);

  assert_single_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !redirect);

  assert_nmi_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (nmiReq && commitValid && !aboveNmi && !redirect)
      |=> (redirect && causeVector == 8'h06 && resumable && !irqEnable
           && savedPc == $past(commitPc)));

  assert_abort_R7: assert property (@(posedge clk) disable iff (rst)
    (hwResetReq && !redirect) |=> (redirect && !resumable && causeVector == 8'h01 && $stable(savedPc)));

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (rst)
    (irqReq && !irqEnable && othersIdle && !redirect) |=> !redirect);
endmodule

bind commit_event_unit cev_checker #(.PC_W(PC_W)) uChecker (
  .clk          (clk),
  .rst          (rst),
  .commitValid  (commitValid),
  .commitPc     (commitPc),
  .hwResetReq   (hwResetReq),
  .machineCheck (machineCheck),
  .initReq      (initReq),
  .smiReq       (smiReq),
  .softIntValid (softIntValid),
  .trapReq      (trapReq),
  .nmiReq       (nmiReq),
  .irqReq       (irqReq),
  .execFault    (execFault),
  .fetchFault   (fetchFault),
  .eret         (eret),
  .flush        (flush),
  .redirect     (redirect),
  .causeVector  (causeVector),
  .savedPc      (savedPc),
  .resumable    (resumable),
  .irqEnable    (irqEnable)
);

// File: tb/tb_commit_event_unit.sv
module tb_commit_event_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        commitValid = 1'b0;
  logic [31:0] commitPc = 32'h1000;
  logic        commitTaken = 1'b0;
  logic [31:0] commitTarget = 32'h0;
  logic [31:0] handlerBase = 32'h8000_0000;
  logic        hwResetReq = 1'b0, machineCheck = 1'b0, initReq = 1'b0, smiReq = 1'b0;
  logic        softIntValid = 1'b0;
  logic [7:0]  softIntVector = 8'h0;
  logic        trapReq = 1'b0, nmiReq = 1'b0, irqReq = 1'b0;
  logic [2:0]  execFault = 3'b0;
  logic [1:0]  fetchFault = 2'b0;
  logic        eret = 1'b0, irqEnWe = 1'b0, irqEnVal = 1'b0;
  logic        flush, redirect, resumable, irqEnable;
  logic [31:0] redirectPc, savedPc;
  logic [7:0]  causeVector;

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;
  string tag = "R1";

  // reference state
  bit          expFlush, expRedir, expRes, expEn, expSavedEn;
  logic [31:0] expRpc, expSavedPc;
  logic [7:0]  expCause;

  always #10 clk = ~clk;

  commit_event_unit dut (
    .clk(clk), .rst(rst), .commitValid(commitValid), .commitPc(commitPc),
    .commitTaken(commitTaken), .commitTarget(commitTarget), .handlerBase(handlerBase),
    .hwResetReq(hwResetReq), .machineCheck(machineCheck), .initReq(initReq), .smiReq(smiReq),
    .softIntValid(softIntValid), .softIntVector(softIntVector), .trapReq(trapReq),
    .nmiReq(nmiReq), .irqReq(irqReq), .execFault(execFault), .fetchFault(fetchFault),
    .eret(eret), .irqEnWe(irqEnWe), .irqEnVal(irqEnVal),
    .flush(flush), .redirect(redirect), .redirectPc(redirectPc), .causeVector(causeVector),
    .savedPc(savedPc), .resumable(resumable), .irqEnable(irqEnable)
  );

  // Behavioural reference: class 0 = resume at current, 1 = sequential, 2 = abort
  always @(posedge clk) begin
    bit found;
    int cls;
    logic [7:0] vec;
    started = 1;
    if (rst) begin
      expFlush = 0; expRedir = 0; expRes = 0; expEn = 0; expSavedEn = 0;
      expRpc = 0; expSavedPc = 0; expCause = 0;
    end else begin
      found = 1; cls = 0; vec = 0;
      if (hwResetReq)                          begin vec = 8'h01; cls = 2; end
      else if (machineCheck)                   begin vec = 8'h02; cls = 2; end
      else if (commitValid && initReq)         vec = 8'h03;
      else if (commitValid && smiReq)          vec = 8'h04;
      else if (commitValid && softIntValid)    begin vec = softIntVector; cls = 1; end
      else if (commitValid && trapReq)         begin vec = 8'h05; cls = 1; end
      else if (commitValid && nmiReq)          vec = 8'h06;
      else if (commitValid && irqReq && expEn) vec = 8'h20;
      else if (commitValid && execFault[0])    vec = 8'h08;
      else if (commitValid && execFault[1])    vec = 8'h09;
      else if (commitValid && execFault[2])    vec = 8'h0A;
      else if (commitValid && fetchFault[0])   vec = 8'h0B;
      else if (commitValid && fetchFault[1])   vec = 8'h0C;
      else found = 0;
      if (!expRedir && found) begin
        expCause = vec;
        expRpc = handlerBase + 32'(vec) * 16;
        expSavedEn = expEn;
        expEn = 0;
        if (cls == 2) expRes = 0;
        else begin
          expRes = 1;
          expSavedPc = (cls == 1) ? (commitTaken ? commitTarget : commitPc + 4) : commitPc;
        end
        expRedir = 1;
      end else if (!expRedir && eret && expRes) begin
        expRpc = expSavedPc;
        expEn = expSavedEn;
        expRedir = 1;
      end else begin
        if (irqEnWe) expEn = irqEnVal;
        expRedir = 0;
      end
      expFlush = expRedir;
    end
  end

  // Compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (flush !== expFlush || redirect !== expRedir || redirectPc !== expRpc ||
          causeVector !== expCause || savedPc !== expSavedPc || resumable !== expRes ||
          irqEnable !== expEn) begin
        errors++;
        $display("FAIL %s t=%0t flush %0b/%0b redirect %0b/%0b rpc %h/%h cause %h/%h spc %h/%h res %0b/%0b en %0b/%0b",
                 tag, $time, flush, expFlush, redirect, expRedir, redirectPc, expRpc,
                 causeVector, expCause, savedPc, expSavedPc, resumable, expRes, irqEnable, expEn);
      end
    end
  end

  task automatic clearIn();
    hwResetReq = 0; machineCheck = 0; initReq = 0; smiReq = 0; softIntValid = 0;
    trapReq = 0; nmiReq = 0; irqReq = 0; execFault = 0; fetchFault = 0;
    eret = 0; irqEnWe = 0; commitTaken = 0; commitValid = 1;
  endtask

  task automatic nextCycle();
    @(negedge clk); #1;
    clearIn();
    commitPc = commitPc + 4;
    commitTarget = 32'h4000 + commitPc;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) nextCycle();
  endtask

  task automatic raiseFrom(input int lvl);
    hwResetReq    = (lvl <= 0);
    machineCheck  = (lvl <= 1);
    initReq       = (lvl <= 2);
    smiReq        = (lvl <= 3);
    softIntValid  = (lvl <= 4);
    softIntVector = 8'h41;
    trapReq       = (lvl <= 5);
    nmiReq        = (lvl <= 6);
    irqReq        = (lvl <= 7);
    execFault     = {(lvl <= 10), (lvl <= 9), (lvl <= 8)};
    fetchFault    = {(lvl <= 12), (lvl <= 11)};
  endtask

  initial begin
    clearIn();
    repeat (3) @(negedge clk);
    #1 rst = 0;
    tag = "R1"; idle(2);

    tag = "R8"; nextCycle(); irqEnWe = 1; irqEnVal = 1;
    nextCycle(); irqReq = 1;                       // granted, vector 0x20
    tag = "R11"; idle(2);
    nextCycle(); eret = 1;                          // restores enable 1
    idle(2);
    tag = "R8"; nextCycle(); irqEnWe = 1; irqEnVal = 0;
    nextCycle(); irqReq = 1;                        // masked
    idle(1);
    tag = "R6"; nextCycle(); nmiReq = 1;           // not masked
    idle(2);
    tag = "R5"; nextCycle(); trapReq = 1; commitTaken = 1;
    idle(2);
    nextCycle(); softIntValid = 1; softIntVector = 8'h80;
    idle(2);
    tag = "R4"; nextCycle(); execFault = 3'b110;   // FP beats alignment
    idle(2);
    nextCycle(); fetchFault = 2'b10;
    idle(2);
    tag = "R3"; handlerBase = 32'h0001_0000;
    nextCycle(); fetchFault = 2'b01;
    idle(2);
    tag = "R9"; nextCycle(); commitValid = 0; nmiReq = 1; trapReq = 1;
    idle(2);
    tag = "R7"; nextCycle(); commitValid = 0; machineCheck = 1;
    idle(2);
    tag = "R12"; nextCycle(); eret = 1;            // not resumable: ignored
    idle(2);
    tag = "R10"; nextCycle(); nmiReq = 1; execFault = 3'b001;
    idle(3);
    tag = "R12"; nextCycle(); nmiReq = 1;
    nextCycle(); nmiReq = 1;                        // blocked by pending redirect
    nextCycle(); nmiReq = 1;                        // accepted again
    idle(2);
    nextCycle(); trapReq = 1; eret = 1;             // grant beats return
    idle(2);

    tag = "R2";
    for (int lvl = 0; lvl < 13; lvl++) begin
      nextCycle(); irqEnWe = 1; irqEnVal = 1;
      nextCycle(); raiseFrom(lvl);
      idle(2);
      nextCycle(); eret = 1;
      idle(2);
    end

    tag = "R1"; nextCycle(); rst = 1;
    nextCycle(); rst = 0;
    idle(2);

    tag = "R2";
    for (int i = 0; i < 400; i++) begin
      nextCycle();
      commitValid  = ($urandom_range(0, 7) != 0);
      commitTaken  = $urandom_range(0, 1);
      hwResetReq   = ($urandom_range(0, 60) == 0);
      machineCheck = ($urandom_range(0, 60) == 0);
      initReq      = ($urandom_range(0, 30) == 0);
      smiReq       = ($urandom_range(0, 30) == 0);
      softIntValid = ($urandom_range(0, 15) == 0);
      softIntVector = 8'($urandom_range(0, 255));
      trapReq      = ($urandom_range(0, 15) == 0);
      nmiReq       = ($urandom_range(0, 15) == 0);
      irqReq       = ($urandom_range(0, 4) == 0);
      execFault    = ($urandom_range(0, 5) == 0) ? 3'($urandom_range(1, 7)) : 3'b0;
      fetchFault   = ($urandom_range(0, 5) == 0) ? 2'($urandom_range(1, 3)) : 2'b0;
      eret         = ($urandom_range(0, 3) == 0);
      irqEnWe      = ($urandom_range(0, 5) == 0);
      irqEnVal     = $urandom_range(0, 1);
    end
    idle(3);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired: actual hung, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule